// File: doc/BRIEF.md
# Programmable I2C Serial Clock Generator

This block produces the serial clock of an I2C bus master from one source clock. Two 6-bit configuration fields set the rate. The divider-select field is split into two 3-bit groups, and each group picks a sub-divider from a fixed table. The filter-rate field gives a count C that has two uses. It adds a correction term to the overall ratio, and it paces a one-cycle strobe that a downstream glitch filter uses to time its samples. The overall ratio is B × (A + 2·floor(3C/B)) source cycles per SCL period. The block shows this value on an output, so other logic can see the rate in use.

SCL is open drain. The block only ever pulls the line low, and it releases the line for the high phase. Another device may hold the line low after it is released (clock stretching). While that happens the high-phase count is frozen. Both fields may be changed at any time. A new ratio is taken up only when the next SCL period begins, so a period is never cut short. Both fields are registered on entry. Reset loads a divider field of 0x00 and a rate field of 0x10.

The period sequencer has four states. **IDLE** releases SCL and waits for enable. **LOW** drives SCL low. **HIGH** releases SCL and counts. **HOLD** releases SCL and freezes the count while the line is held low by another device. The transitions are:
- IDLE→LOW when enable is high. This latches the ratio.
- LOW→HIGH when the low count ends.
- HIGH→HOLD when SCL is sensed low.
- HOLD→HIGH when SCL is sensed high again.
- HIGH→LOW when the high count ends. This latches the new ratio.
- Any state→IDLE when enable is low.

Top module: `scl_divgen`

## Requirements
- R1: The divider-select field `div_sel` is split as follows. Group A is the pattern {bit5, bit1, bit0}, with bit5 as its MSB. Group B is the pattern {bit4, bit3, bit2}, with bit4 as its MSB. Bit 0 is the LSB of the field.
- R2: Group A patterns 0 to 7 select the sub-dividers 18, 20, 24, 30, 10, 12, 14 and 16, in that order.
- R3: Group B pattern p selects the sub-divider 16·2^p, which gives 16 up to 2048.
- R4: `ratio` equals B × (A + 2·floor(3C/B)), where C is the rate-field value. It reflects the fields presented one clock earlier. For example, div 0x0C with C=16 gives 2304, div 0x00 with C=1 gives 288, and div 0x03 with C=0x23 gives 672.
- R5: A rate field of 0 is treated as C=16. It gives the same ratio and the same strobe spacing as 0x10.
- R6: `sample_stb` is high for one cycle in every C source cycles. When C=1 it is high on every cycle.
- R7: With no stretching, one SCL period lasts `ratio` cycles. `scl_oe` is high for ratio/2 cycles and then low for the remaining cycles.
- R8: A ratio change made during a period does not alter that period. It takes effect from the next low phase.
- R9: `scl_oe`=1 means the block pulls SCL low. The block never drives SCL high. It drives low only in the low phase.
- R10: While the block has released SCL and `scl_in` reads low, the high count holds. Each stretch of N cycles adds N+1 cycles to the period.
- R11: While `enable` is low, `scl_oe` is 0 from the next cycle and the sequencer idles. Once `enable` is high, `scl_oe` goes to 1 on the next cycle.
- R12: After reset, `ratio` is 384 (div 0x00 with C=16) and `scl_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL sequencer |
| div_sel | input | 6 | Divider-select field (groups A and B) |
| rate_sel | input | 6 | Filter-rate field C (0 means 16) |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| ratio | output | 16 | Current computed divide ratio |
| sample_stb | output | 1 | Filter sample strobe, one cycle every C |

## Verification
The ratio is checked against all 64 divider fields at five rate values. Rate values 1, 16, 35, 52 and 63 are used, so the cases with a correction term of zero and of non-zero are both covered. This also separates the two group tables and the bit order of each group. Single hand-picked vectors check rate 0 against 0x10, and a field with bit 5 set checks the group-A MSB.

SCL is run at two ratios. The ratio is changed at the start of a period, which shows whether the period in progress keeps its old length. One high phase is stretched for 20 cycles to tell a frozen count from a running one. Enable is dropped during a low phase to confirm an immediate release.

The strobe spacing is measured at rates 5, 0 and 1. These show the period set by the count, the default used for zero, and the case with no gap.

// File: rtl/scl_divgen_pkg.sv
`timescale 1ns/1ps
package scl_divgen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    // Group-A sub-divider lookup (R2)
    function automatic logic [4:0] grp_a_div(input logic [2:0] pat);
        logic [4:0] v;
        unique case (pat)
            3'd0: v = 5'd18;
            3'd1: v = 5'd20;
            3'd2: v = 5'd24;
            3'd3: v = 5'd30;
            3'd4: v = 5'd10;
            3'd5: v = 5'd12;
            3'd6: v = 5'd14;
            default: v = 5'd16;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/scl_ratio_calc.sv
`timescale 1ns/1ps
module scl_ratio_calc
    import scl_divgen_pkg::*;
#(
    parameter int FW       = 6,
    parameter int RW       = 16,
    parameter int DEF_RATE = 16
) (
    input  logic [FW-1:0] div_f,
    input  logic [FW-1:0] rate_f,
    output logic [FW-1:0] c_eff,
    output logic [RW-1:0] ratio
);
    localparam int QW      = FW + 2;
    localparam int BASE_SH = 4;

    logic [2:0]    grp_a;
    logic [2:0]    grp_b;
    logic [3:0]    b_shift;
    logic [QW-1:0] tri_c;
    logic [QW-1:0] quot;
    logic [RW-1:0] inner;

    always_comb begin
        grp_a   = {div_f[5], div_f[1:0]};          // R1
        grp_b   = div_f[4:2];                      // R1
        c_eff   = (rate_f == '0) ? FW'(DEF_RATE) : rate_f;   // R5
        b_shift = {1'b0, grp_b} + 4'(BASE_SH);     // B = 16 << pattern (R3)
        tri_c   = QW'(c_eff) * QW'(3);
        quot    = tri_c >> b_shift;
        inner   = RW'(grp_a_div(grp_a)) + (RW'(quot) << 1);
        ratio   = inner << b_shift;                // R4
    end
endmodule

// File: rtl/scl_sample_tick.sv
`timescale 1ns/1ps
module scl_sample_tick #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] c_eff,
    output logic          stb
);
    logic [FW-1:0] tick_cnt;

    // Fires when the count reaches C-1 (R6); >= covers C shrinking mid-count
    assign stb = (tick_cnt >= (c_eff - FW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (stb)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + FW'(1);
    end
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
    import scl_divgen_pkg::*;
#(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          scl_in,
    input  logic [RW-1:0] ratio,
    output logic          scl_oe,
    output phase_e        state,
    output logic [RW-1:0] cnt,
    output logic [RW-1:0] per_q
);
    phase_e        nxt;
    logic [RW-1:0] cnt_n;
    logic [RW-1:0] per_n;
    logic [RW-1:0] lo_len;
    logic [RW-1:0] hi_len;

    assign lo_len = per_q >> 1;                // R7
    assign hi_len = per_q - lo_len;

    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        per_n = per_q;
        unique case (state)
            PH_IDLE: begin
                if (enable) begin
                    nxt   = PH_LOW;
                    cnt_n = '0;
                    per_n = ratio;
                end
            end
            PH_LOW: begin
                if (cnt == lo_len - RW'(1)) begin
                    nxt   = PH_HIGH;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + RW'(1);
                end
            end
            PH_HIGH: begin
                if (!scl_in) begin
                    nxt = PH_HOLD;                 // R10
                end else if (cnt == hi_len - RW'(1)) begin
                    nxt   = PH_LOW;
                    cnt_n = '0;
                    per_n = ratio;                 // R8: latch at boundary only
                end else begin
                    cnt_n = cnt + RW'(1);
                end
            end
            PH_HOLD: begin
                if (scl_in)
                    nxt = PH_HIGH;
            end
        endcase
        if (!enable) begin                         // R11
            nxt   = PH_IDLE;
            cnt_n = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
            per_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
            per_q <= per_n;
        end
    end

    // Open-drain pull-low only in the low phase (R9)
    always_comb begin
        scl_oe = (state == PH_LOW);
    end
endmodule

// File: rtl/scl_divgen.sv
`timescale 1ns/1ps
module scl_divgen
    import scl_divgen_pkg::*;
#(
    parameter int FW       = 6,
    parameter int RW       = 16,
    parameter int DEF_RATE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [5:0]    div_sel,
    input  logic [5:0]    rate_sel,
    input  logic          scl_in,
    output logic          scl_oe,
    output logic [15:0]   ratio,
    output logic          sample_stb
);
    logic [FW-1:0] div_q;
    logic [FW-1:0] rate_q;
    logic [FW-1:0] c_eff;
    phase_e        ph_state;
    logic [RW-1:0] ph_cnt;
    logic [RW-1:0] ph_per;
    logic [RW-1:0] ratio_w;

    // Field capture; reset defaults per R12
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            rate_q <= FW'(DEF_RATE);
        end else begin
            div_q  <= FW'(div_sel);
            rate_q <= FW'(rate_sel);
        end
    end

    scl_ratio_calc #(.FW(FW), .RW(RW), .DEF_RATE(DEF_RATE)) u_calc (
        .div_f  (div_q),
        .rate_f (rate_q),
        .c_eff  (c_eff),
        .ratio  (ratio_w)
    );

    scl_sample_tick #(.FW(FW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .c_eff (c_eff),
        .stb   (sample_stb)
    );

    scl_phase_fsm #(.RW(RW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .scl_in (scl_in),
        .ratio  (ratio_w),
        .scl_oe (scl_oe),
        .state  (ph_state),
        .cnt    (ph_cnt),
        .per_q  (ph_per)
    );

    assign ratio = 16'(ratio_w);
endmodule

// File: rtl/scl_divgen_chk.sv
`timescale 1ns/1ps
module scl_divgen_chk
    import scl_divgen_pkg::*;
#(
    parameter int FW = 6,
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          scl_in,
    input logic          scl_oe,
    input logic          sample_stb,
    input logic [15:0]   ratio,
    input logic [FW-1:0] c_eff,
    input phase_e        ph_state,
    input logic [RW-1:0] ph_cnt,
    input logic [RW-1:0] ph_per
);
    assert_ratio_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= 16'd160) && (ratio <= 16'd61440));

    assert_release_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !scl_oe);

    assert_stretch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !scl_oe && !scl_in && (ph_state == PH_HIGH || ph_state == PH_HOLD))
        |=> (ph_state == PH_IDLE || $stable(ph_cnt)));

    assert_latch_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph_per) |-> (ph_state == PH_LOW && ph_cnt == '0));

    assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && c_eff != FW'(1)) |=> (!sample_stb || c_eff == FW'(1)));
endmodule

bind scl_divgen scl_divgen_chk #(.FW(FW), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_in     (scl_in),
    .scl_oe     (scl_oe),
    .sample_stb (sample_stb),
    .ratio      (ratio),
    .c_eff      (c_eff),
    .ph_state   (ph_state),
    .ph_cnt     (ph_cnt),
    .ph_per     (ph_per)
);

// File: tb/scl_divgen_bench.sv
`timescale 1ns/1ps
module scl_divgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] div_sel = 6'h00;
    logic [5:0] rate_sel = 6'h10;
    logic       tb_stretch = 1'b0;
    logic       scl_line;
    logic       scl_oe;
    logic [15:0] ratio;
    logic       sample_stb;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit fin = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Open-drain line: low when DUT pulls or another device stretches
    assign scl_line = !scl_oe && !tb_stretch;

    scl_divgen u_scl_divgen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .div_sel(div_sel), .rate_sel(rate_sel), .scl_in(scl_line),
        .scl_oe(scl_oe), .ratio(ratio), .sample_stb(sample_stb)
    );

    function automatic int ref_ratio(int d, int r);
        int a_tab[8] = '{18, 20, 24, 30, 10, 12, 14, 16};
        int ga = ((d >> 5) & 1) * 4 + (d & 3);
        int b  = 16 << ((d >> 2) & 7);
        int c  = (r == 0) ? 16 : r;
        return b * (a_tab[ga] + 2 * ((3 * c) / b));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: modes 0 idle, 1 pulling low, 2 released counting, 3 stretched
    int m_div, m_rate, m_mode, m_left, m_per, m_scnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_rate = 16; m_mode = 0; m_left = 0; m_per = 0; m_scnt = 0;
        end else begin
            int r_now, c_now;
            r_now = ref_ratio(m_div, m_rate);
            c_now = (m_rate == 0) ? 16 : m_rate;
            if (m_scnt >= c_now - 1) m_scnt = 0; else m_scnt = m_scnt + 1;
            if (!enable) begin
                m_mode = 0;
            end else begin
                case (m_mode)
                    0: begin m_per = r_now; m_left = m_per / 2; m_mode = 1; end
                    1: begin
                        m_left = m_left - 1;
                        if (m_left == 0) begin m_mode = 2; m_left = m_per - m_per / 2; end
                    end
                    2: begin
                        if (!scl_line) m_mode = 3;
                        else begin
                            m_left = m_left - 1;
                            if (m_left == 0) begin m_per = r_now; m_left = m_per / 2; m_mode = 1; end
                        end
                    end
                    default: if (scl_line) m_mode = 2;
                endcase
            end
            m_div = div_sel; m_rate = rate_sel;
        end
    end

    // Every-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            int c_m;
            c_m = (m_rate == 0) ? 16 : m_rate;
            chk("R4 ratio per clock", ratio, ref_ratio(m_div, m_rate));
            chk(m_mode == 0 ? "R11 scl_oe idle" : (m_mode == 3 ? "R10 scl_oe stretched" : "R7 R9 scl_oe phase"),
                scl_oe, (m_mode == 1) ? 1 : 0);
            chk("R6 strobe per clock", sample_stb, (m_scnt >= c_m - 1) ? 1 : 0);
        end
    end

    task automatic summary();
        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            n_bad++;
            $display("FAIL R7 watchdog: actual=%0d cycles expected<150000", cyc);
            summary();
        end
    end

    task automatic set_vec(input int d, input int r, input int exp, input string tag);
        div_sel = 6'(d); rate_sel = 6'(r);
        @(negedge clk);
        chk(tag, ratio, exp);
    endtask

    // Called at the negedge of the first low cycle; returns at the next such negedge
    task automatic count_period(output int per);
        per = 0;
        while (scl_oe) begin per++; @(negedge clk); end
        while (!scl_oe) begin per++; @(negedge clk); end
    endtask

    task automatic sync_rise();
        @(negedge clk);
        while (scl_oe) @(negedge clk);
        while (!scl_oe) @(negedge clk);
    endtask

    task automatic strobe_gap(output int gap);
        while (!sample_stb) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sample_stb);
    endtask

    initial begin
        int p, lo, g;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ratio", ratio, 384);
        chk("R12 reset scl_oe", scl_oe, 0);

        // Single vectors
        set_vec(6'h0C, 16, 2304, "R1 R3 div 0x0C C=16");
        set_vec(6'h00, 16, 384, "R4 div 0x00 C=16");
        set_vec(6'h00, 1, 288, "R4 div 0x00 C=1");
        set_vec(6'h03, 6'h23, 672, "R2 div 0x03 C=0x23");
        set_vec(6'h00, 0, 384, "R5 rate zero as 0x10");
        set_vec(6'h21, 16, 288, "R1 group A msb bit5");
        set_vec(6'h1C, 16, 36864, "R3 group B top");
        // Full sweep
        for (int d = 0; d < 64; d++) begin
            set_vec(d, 1, ref_ratio(d, 1), "R2 R3 sweep C=1");
            set_vec(d, 16, ref_ratio(d, 16), "R2 R3 sweep C=16");
            set_vec(d, 35, ref_ratio(d, 35), "R4 sweep C=35");
            set_vec(d, 52, ref_ratio(d, 52), "R4 sweep C=52");
            set_vec(d, 63, ref_ratio(d, 63), "R4 sweep C=63");
        end

        // SCL run at ratio 160
        div_sel = 6'h20; rate_sel = 6'd1;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R11 start pulls low next cycle", scl_oe, 1);
        sync_rise();
        lo = 0;
        while (scl_oe) begin lo++; @(negedge clk); end
        chk("R7 low phase 160/2", lo, 80);
        sync_rise();
        count_period(p);
        chk("R7 period 160", p, 160);

        // R8: change at period start, current period unchanged
        div_sel = 6'h00;
        count_period(p);
        chk("R8 old ratio kept", p, 160);
        count_period(p);
        chk("R8 new ratio 288", p, 288);

        // R10: stretch 20 cycles in high phase
        fork
            count_period(p);
            begin
                while (scl_oe) @(negedge clk);
                repeat (10) @(negedge clk);
                tb_stretch = 1'b1;
                repeat (20) begin
                    @(negedge clk);
                    chk("R10 released while stretched", scl_oe, 0);
                end
                tb_stretch = 1'b0;
            end
        join
        chk("R10 stretched period 288+21", p, 309);

        // R11: drop enable in low phase
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R11 release after disable", scl_oe, 0);
        repeat (30) @(negedge clk);
        chk("R11 stays released", scl_oe, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R11 restart low", scl_oe, 1);
        count_period(p);
        chk("R7 period after restart", p, 288);

        // R6 / R5 strobe spacing
        rate_sel = 6'd5;
        repeat (3) @(negedge clk);
        strobe_gap(g);
        chk("R6 strobe gap C=5", g, 5);
        rate_sel = 6'd0;
        repeat (3) @(negedge clk);
        strobe_gap(g);
        strobe_gap(g);
        chk("R5 strobe gap C=0 as 16", g, 16);
        rate_sel = 6'd1;
        repeat (3) @(negedge clk);
        strobe_gap(g);
        chk("R6 strobe gap C=1", g, 1);

        repeat (20) @(negedge clk);
        summary();
    end
endmodule